// File: doc/BRIEF.md
# Multi-Lane Packet Byte Striper

This transmit-side unit takes packet bytes from the link layer one symbol per cycle. It frames each packet with a start symbol and an end symbol, and spreads the result across 1, 4 or 8 lanes. Rows are assembled one lane position per cycle. A finished row appears on the output with a one-cycle strobe: each lane carries an 8-bit symbol and a control-symbol flag.

Framing symbols may only sit at legal lane positions. A start goes on a lane that is a multiple of four, and an end goes on a lane of the form 4k+3. A packet may follow the previous one directly, mid-row. If it does not, the rest of the row is filled with PAD.

Ordered sets and logical idle are always whole rows that repeat one symbol on every active lane. An ordered-set request is remembered and is served at the next row boundary, after any packet in progress. Scrambling, line coding and serialization happen downstream.

Top module: `lane_striper`

## Requirements
- R1: While reset is asserted, `row_vld`, `pkt_ready`, every lane symbol and every control flag are 0.
- R2: With `lane_mode` = 0 (one lane), each framed symbol is emitted as its own row on lane 0, in order: start, payload bytes, end.
- R3: A packet opens with a control symbol: 0xFB when `pkt_kind` = 0 or 0x5C when `pkt_kind` = 1. With 4 or 8 lanes it sits on a lane that is a multiple of 4, and a packet that follows idle, PAD or an ordered set starts on lane 0.
- R4: A packet closes with a control symbol on the lane after its last payload byte: 0xFD normally, or 0xFE when `pkt_bad` was 1 on the beat that had `pkt_eop`. With 4 or 8 lanes it sits only on lanes 3 or 7.
- R5: Payload bytes are placed with the control flag 0, in ascending lane order, and wrap to lane 0 of the next row.
- R6: If the next packet's first beat is offered on the cycle after the end symbol is placed, and the row is not full, that packet's start symbol takes the next lane of the same row.
- R7: If a packet ends before the last active lane and no packet is offered on the next cycle, every remaining lane of that row carries PAD (0xF7, control flag 1).
- R8: A pulse on `os_req` produces, once the current row is complete, four consecutive rows. The first carries COM (0xBC) and the next three carry SKP (0x1C) on every active lane, all with the control flag set.
- R9: When no packet or ordered set is pending at a row boundary, a logical-idle row is emitted: byte 0x00 with control flag 0 on all lanes.
- R10: `lane_mode` selects 1 lane (0), 4 lanes (1) or 8 lanes (2 or 3). Lanes above the active width always carry 0x00 with flag 0.
- R11: `pkt_ready` is high only while payload is being taken. It is low in the cycle after a beat with `pkt_eop` is accepted, and while start symbols, PAD fills or ordered sets are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_mode | input | 2 | Active lane count: 0 = 1, 1 = 4, 2/3 = 8 |
| pkt_valid | input | 1 | Packet beat offered |
| pkt_ready | output | 1 | Packet beat accepted on this edge when valid |
| pkt_data | input | 8 | Payload byte |
| pkt_sop | input | 1 | First beat of a packet |
| pkt_eop | input | 1 | Last beat of a packet |
| pkt_kind | input | 1 | Start symbol choice, sampled with the first beat |
| pkt_bad | input | 1 | Nullify marker, sampled with the last beat |
| os_req | input | 1 | Request one ordered set |
| row_vld | output | 1 | A completed row is on the lane outputs |
| lane_data | output | LANES*8 | Lane symbols, lane i at bits [8i+7:8i] |
| lane_k | output | LANES | Control-symbol flag per lane |

## Verification
The lane-position properties hold only for packets whose payload length is 2 mod 4, so that start, payload and end fill whole groups of four lanes. They also assume that `lane_mode` changes only while idle rows are flowing. The stimulus uses only such lengths in the 4- and 8-lane modes and any length in the single-lane mode. It changes the width only after several idle cycles. Payload bytes are never zero, so a logical-idle row cannot be mistaken for a data row.

// File: rtl/lane_striper_pkg.sv
package lane_striper_pkg;

  localparam int unsigned GROUP  = 4;
  localparam int unsigned OS_LEN = 4;

  localparam logic [7:0] SYM_STP  = 8'hFB;
  localparam logic [7:0] SYM_SDP  = 8'h5C;
  localparam logic [7:0] SYM_END  = 8'hFD;
  localparam logic [7:0] SYM_EDB  = 8'hFE;
  localparam logic [7:0] SYM_PAD  = 8'hF7;
  localparam logic [7:0] SYM_COM  = 8'hBC;
  localparam logic [7:0] SYM_SKP  = 8'h1C;
  localparam logic [7:0] SYM_IDLE = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_TAIL,
    ST_GAP,
    ST_OSET
  } stripe_state_e;

endpackage

// File: rtl/lane_striper_ctrl.sv
module lane_striper_ctrl
  import lane_striper_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned POSW = $clog2(LANES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      lane_mode,
  input  logic            pkt_valid,
  input  logic [7:0]      pkt_data,
  input  logic            pkt_sop,
  input  logic            pkt_eop,
  input  logic            pkt_kind,
  input  logic            pkt_bad,
  input  logic            os_req,
  output logic            pkt_ready,
  output logic [POSW-1:0] last_pos,
  output logic            wr_en,
  output logic [POSW-1:0] wr_pos,
  output logic [7:0]      wr_sym,
  output logic            wr_k,
  output logic            wr_last,
  output logic            pad_fill,
  output logic            bc_en,
  output logic [7:0]      bc_sym,
  output logic            bc_k
);

  localparam int unsigned OSW = $clog2(OS_LEN);

  stripe_state_e   state, state_n;
  logic [POSW-1:0] pos, pos_n, pos_adv;
  logic [OSW-1:0]  os_cnt, os_cnt_n;
  logic            os_pend, os_pend_n;
  logic            bad_q, bad_n;

  always_comb begin
    case (lane_mode)
      2'd0:    last_pos = '0;
      2'd1:    last_pos = POSW'(GROUP - 1);
      default: last_pos = POSW'(LANES - 1);
    endcase
  end

  assign pos_adv   = (pos == last_pos) ? '0 : pos + 1'b1;
  assign wr_pos    = pos;
  assign wr_last   = (pos == last_pos);
  assign pkt_ready = (state == ST_DATA);

  always_comb begin
    state_n   = state;
    pos_n     = pos;
    os_cnt_n  = os_cnt;
    os_pend_n = os_pend | os_req;
    bad_n     = bad_q;
    wr_en     = 1'b0;
    wr_sym    = SYM_IDLE;
    wr_k      = 1'b0;
    pad_fill  = 1'b0;
    bc_en     = 1'b0;
    bc_sym    = SYM_IDLE;
    bc_k      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (os_pend || os_req) begin
          bc_en     = 1'b1;
          bc_sym    = SYM_COM;
          bc_k      = 1'b1;
          os_cnt_n  = OSW'(1);
          os_pend_n = 1'b0;
          state_n   = ST_OSET;
        end else if (pkt_valid && pkt_sop) begin
          wr_en   = 1'b1;
          wr_sym  = pkt_kind ? SYM_SDP : SYM_STP;
          wr_k    = 1'b1;
          pos_n   = pos_adv;
          state_n = ST_DATA;
        end else begin
          bc_en = 1'b1;
        end
      end
      ST_DATA: begin
        if (pkt_valid) begin
          wr_en  = 1'b1;
          wr_sym = pkt_data;
          pos_n  = pos_adv;
          if (pkt_eop) begin
            bad_n   = pkt_bad;
            state_n = ST_TAIL;
          end
        end
      end
      ST_TAIL: begin
        wr_en   = 1'b1;
        wr_sym  = bad_q ? SYM_EDB : SYM_END;
        wr_k    = 1'b1;
        pos_n   = pos_adv;
        state_n = (pos == last_pos) ? ST_IDLE : ST_GAP;
      end
      ST_GAP: begin
        if (pkt_valid && pkt_sop) begin
          wr_en   = 1'b1;
          wr_sym  = pkt_kind ? SYM_SDP : SYM_STP;
          wr_k    = 1'b1;
          pos_n   = pos_adv;
          state_n = ST_DATA;
        end else begin
          pad_fill = 1'b1;
          pos_n    = '0;
          state_n  = ST_IDLE;
        end
      end
      ST_OSET: begin
        bc_en    = 1'b1;
        bc_sym   = SYM_SKP;
        bc_k     = 1'b1;
        os_cnt_n = os_cnt + 1'b1;
        if (os_cnt == OSW'(OS_LEN - 1)) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pos     <= '0;
      os_cnt  <= '0;
      os_pend <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      state   <= state_n;
      pos     <= pos_n;
      os_cnt  <= os_cnt_n;
      os_pend <= os_pend_n;
      bad_q   <= bad_n;
    end
  end

endmodule

// File: rtl/lane_striper_row.sv
module lane_striper_row
  import lane_striper_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned POSW = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [POSW-1:0]    last_pos,
  input  logic               wr_en,
  input  logic [POSW-1:0]    wr_pos,
  input  logic [7:0]         wr_sym,
  input  logic               wr_k,
  input  logic               wr_last,
  input  logic               pad_fill,
  input  logic               bc_en,
  input  logic [7:0]         bc_sym,
  input  logic               bc_k,
  output logic               row_vld,
  output logic [LANES*8-1:0] lane_data,
  output logic [LANES-1:0]   lane_k
);

  logic [LANES*8-1:0] buf_d, buf_d_n;
  logic [LANES-1:0]   buf_k, buf_k_n;
  logic               buf_en, emit;

  assign emit   = bc_en | pad_fill | (wr_en & wr_last);
  assign buf_en = bc_en | pad_fill | wr_en;

  always_comb begin
    buf_d_n = buf_d;
    buf_k_n = buf_k;
    for (int i = 0; i < int'(LANES); i++) begin
      if (wr_en && i == int'(wr_pos)) begin
        buf_d_n[i*8 +: 8] = wr_sym;
        buf_k_n[i]        = wr_k;
      end
      if (pad_fill && i >= int'(wr_pos) && i <= int'(last_pos)) begin
        buf_d_n[i*8 +: 8] = SYM_PAD;
        buf_k_n[i]        = 1'b1;
      end
      if (bc_en && i <= int'(last_pos)) begin
        buf_d_n[i*8 +: 8] = bc_sym;
        buf_k_n[i]        = bc_k;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_d <= '0;
      buf_k <= '0;
    end else if (buf_en) begin
      buf_d <= emit ? '0 : buf_d_n;
      buf_k <= emit ? '0 : buf_k_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_data <= '0;
      lane_k    <= '0;
    end else if (emit) begin
      lane_data <= buf_d_n;
      lane_k    <= buf_k_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_vld <= 1'b0;
    else        row_vld <= emit;
  end

endmodule

// File: rtl/lane_striper.sv
module lane_striper
  import lane_striper_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         lane_mode,
  input  logic               pkt_valid,
  output logic               pkt_ready,
  input  logic [7:0]         pkt_data,
  input  logic               pkt_sop,
  input  logic               pkt_eop,
  input  logic               pkt_kind,
  input  logic               pkt_bad,
  input  logic               os_req,
  output logic               row_vld,
  output logic [LANES*8-1:0] lane_data,
  output logic [LANES-1:0]   lane_k
);

  localparam int unsigned POSW = $clog2(LANES);

  logic [1:0]      rst_sync;
  logic            rst_int_n;
  logic [POSW-1:0] last_pos, wr_pos;
  logic            wr_en, wr_k, wr_last, pad_fill, bc_en, bc_k;
  logic [7:0]      wr_sym, bc_sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lane_striper_ctrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lane_mode (lane_mode),
    .pkt_valid (pkt_valid),
    .pkt_data  (pkt_data),
    .pkt_sop   (pkt_sop),
    .pkt_eop   (pkt_eop),
    .pkt_kind  (pkt_kind),
    .pkt_bad   (pkt_bad),
    .os_req    (os_req),
    .pkt_ready (pkt_ready),
    .last_pos  (last_pos),
    .wr_en     (wr_en),
    .wr_pos    (wr_pos),
    .wr_sym    (wr_sym),
    .wr_k      (wr_k),
    .wr_last   (wr_last),
    .pad_fill  (pad_fill),
    .bc_en     (bc_en),
    .bc_sym    (bc_sym),
    .bc_k      (bc_k)
  );

  lane_striper_row #(.LANES(LANES)) u_row (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .last_pos  (last_pos),
    .wr_en     (wr_en),
    .wr_pos    (wr_pos),
    .wr_sym    (wr_sym),
    .wr_k      (wr_k),
    .wr_last   (wr_last),
    .pad_fill  (pad_fill),
    .bc_en     (bc_en),
    .bc_sym    (bc_sym),
    .bc_k      (bc_k),
    .row_vld   (row_vld),
    .lane_data (lane_data),
    .lane_k    (lane_k)
  );

endmodule

// File: rtl/lane_striper_chk.sv
module lane_striper_chk
  import lane_striper_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         lane_mode,
  input logic               pkt_valid,
  input logic               pkt_ready,
  input logic               pkt_eop,
  input logic               row_vld,
  input logic [LANES*8-1:0] lane_data,
  input logic [LANES-1:0]   lane_k
);

  int   act;
  logic start_bad, end_bad, pad_bad, os_bad, inact_bad;

  always_comb begin
    act       = (lane_mode == 2'd0) ? 1 : (lane_mode == 2'd1) ? int'(GROUP) : int'(LANES);
    start_bad = 1'b0;
    end_bad   = 1'b0;
    pad_bad   = 1'b0;
    os_bad    = 1'b0;
    inact_bad = 1'b0;
    for (int i = 0; i < int'(LANES); i++) begin
      if (act > 1 && lane_k[i] && (lane_data[i*8 +: 8] == SYM_STP || lane_data[i*8 +: 8] == SYM_SDP)
          && (i % int'(GROUP)) != 0)
        start_bad = 1'b1;
      if (act > 1 && lane_k[i] && (lane_data[i*8 +: 8] == SYM_END || lane_data[i*8 +: 8] == SYM_EDB)
          && (i % int'(GROUP)) != int'(GROUP) - 1)
        end_bad = 1'b1;
      if (lane_k[i] && lane_data[i*8 +: 8] == SYM_PAD) begin
        if (i == 0) pad_bad = 1'b1;
        else if (!(lane_k[i-1] && (lane_data[(i-1)*8 +: 8] == SYM_PAD ||
                                   lane_data[(i-1)*8 +: 8] == SYM_END ||
                                   lane_data[(i-1)*8 +: 8] == SYM_EDB)))
          pad_bad = 1'b1;
      end
      if (lane_k[0] && (lane_data[7:0] == SYM_COM || lane_data[7:0] == SYM_SKP) && i < act
          && (lane_data[i*8 +: 8] != lane_data[7:0] || !lane_k[i]))
        os_bad = 1'b1;
      if (i >= act && (lane_data[i*8 +: 8] != 8'h00 || lane_k[i]))
        inact_bad = 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!row_vld && !pkt_ready);
    end
  end

  a_r3_start_lane: assert property (@(posedge clk) disable iff (!rst_n)
    row_vld |-> !start_bad);

  a_r4_end_lane: assert property (@(posedge clk) disable iff (!rst_n)
    row_vld |-> !end_bad);

  a_r7_pad_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
    row_vld |-> !pad_bad);

  a_r8_os_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    row_vld |-> !os_bad);

  a_r10_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    row_vld |-> !inact_bad);

  a_r11_stall_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready && pkt_eop) |=> !pkt_ready);

endmodule

bind lane_striper lane_striper_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lane_mode (lane_mode),
  .pkt_valid (pkt_valid),
  .pkt_ready (pkt_ready),
  .pkt_eop   (pkt_eop),
  .row_vld   (row_vld),
  .lane_data (lane_data),
  .lane_k    (lane_k)
);

// File: tb/lane_striper_bench.sv
`timescale 1ns/1ps
module lane_striper_bench;

  localparam int LANES = 8;

  logic               clk;
  logic               rst_n;
  logic [1:0]         lane_mode;
  logic               pkt_valid, pkt_ready, pkt_sop, pkt_eop, pkt_kind, pkt_bad, os_req;
  logic [7:0]         pkt_data;
  logic               row_vld;
  logic [LANES*8-1:0] lane_data;
  logic [LANES-1:0]   lane_k;

  lane_striper #(.LANES(LANES)) u_lane_striper (
    .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
    .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .pkt_kind(pkt_kind), .pkt_bad(pkt_bad),
    .os_req(os_req), .row_vld(row_vld), .lane_data(lane_data), .lane_k(lane_k)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int idle_rows = 0;
  int seq = 0;
  bit live = 0;
  bit done = 0;

  logic [LANES*8-1:0] exp_d[$];
  logic [LANES-1:0]   exp_k[$];
  string              exp_tag[$];

  logic [7:0] md [LANES];
  logic       mk [LANES];
  int         mpos = 0;
  int         mnl  = 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic m_push(input string tag);
    logic [LANES*8-1:0] d;
    logic [LANES-1:0]   k;
    d = '0; k = '0;
    for (int i = 0; i < LANES; i++) begin
      d[i*8 +: 8] = md[i];
      k[i] = mk[i];
      md[i] = 8'h00;
      mk[i] = 1'b0;
    end
    exp_d.push_back(d);
    exp_k.push_back(k);
    exp_tag.push_back(tag);
    mpos = 0;
  endtask

  task automatic m_place(input logic [7:0] s, input logic k, input string tag);
    md[mpos] = s;
    mk[mpos] = k;
    mpos++;
    if (mpos == mnl) m_push(tag);
  endtask

  task automatic m_pad();
    if (mpos != 0) begin
      for (int i = mpos; i < mnl; i++) begin
        md[i] = 8'hF7;
        mk[i] = 1'b1;
      end
      m_push("R7");
    end
  endtask

  task automatic m_os(input string tag);
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < mnl; i++) begin
        md[i] = (r == 0) ? 8'hBC : 8'h1C;
        mk[i] = 1'b1;
      end
      m_push(tag);
    end
  endtask

  // Scoreboard driver: model first, then drive beats. Entered and left at a negedge.
  task automatic send_pkt(input int len, input bit kind, input bit bad, input bit follow,
                          input int os_beat, input string tag);
    logic [7:0] b [64];
    seq++;
    for (int i = 0; i < len; i++) b[i] = 8'(((seq * 37 + i * 11) % 250) + 1);
    m_place(kind ? 8'h5C : 8'hFB, 1'b1, tag);
    for (int i = 0; i < len; i++) m_place(b[i], 1'b0, tag);
    m_place(bad ? 8'hFE : 8'hFD, 1'b1, tag);
    if (!follow) m_pad();
    if (os_beat >= 0) m_os("R8");
    for (int i = 0; i < len; i++) begin
      pkt_valid = 1'b1;
      pkt_data  = b[i];
      pkt_sop   = (i == 0);
      pkt_eop   = (i == len - 1);
      pkt_kind  = kind;
      pkt_bad   = bad;
      os_req    = (i == os_beat);
      while (!pkt_ready) @(negedge clk);
      @(negedge clk);
      os_req = 1'b0;
    end
    check(pkt_ready == 1'b0, "R11 ready after end beat", {63'd0, pkt_ready}, 64'd0);
    if (!follow) begin
      pkt_valid = 1'b0;
      pkt_sop   = 1'b0;
      pkt_eop   = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic send_os(input string tag);
    m_os(tag);
    os_req = 1'b1;
    @(negedge clk);
    os_req = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // Monitor: pops expected rows as the design produces them; idle rows are counted.
  always @(negedge clk) begin
    if (live && row_vld) begin
      if (lane_data == '0 && lane_k == '0) begin
        idle_rows++;
      end else if (exp_d.size() == 0) begin
        check(1'b0, "R5 unexpected row", lane_data, 64'd0);
      end else begin
        logic [LANES*8-1:0] ed;
        logic [LANES-1:0]   ek;
        string              et;
        ed = exp_d.pop_front();
        ek = exp_k.pop_front();
        et = exp_tag.pop_front();
        check(lane_data == ed, {et, " row symbols"}, lane_data, ed);
        check(lane_k == ek, {et, " row flags"}, {56'd0, lane_k}, {56'd0, ek});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd0, 64'd0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < LANES; i++) begin md[i] = 8'h00; mk[i] = 1'b0; end
    rst_n = 1'b0;
    lane_mode = 2'd0;
    pkt_valid = 1'b0; pkt_data = 8'h00; pkt_sop = 1'b0; pkt_eop = 1'b0;
    pkt_kind = 1'b0; pkt_bad = 1'b0; os_req = 1'b0;
    repeat (3) @(negedge clk);
    check(row_vld == 1'b0, "R1 row_vld in reset", {63'd0, row_vld}, 64'd0);
    check(pkt_ready == 1'b0, "R1 ready in reset", {63'd0, pkt_ready}, 64'd0);
    check(lane_data == '0 && lane_k == '0, "R1 lanes in reset", lane_data, 64'd0);
    rst_n = 1'b1;
    live = 1;
    repeat (5) @(negedge clk);

    // single lane
    mnl = 1;
    send_pkt(3, 1'b0, 1'b0, 1'b0, -1, "R2");
    send_pkt(2, 1'b1, 1'b1, 1'b0, -1, "R2");

    // four lanes
    lane_mode = 2'd1; mnl = 4;
    repeat (4) @(negedge clk);
    send_pkt(6, 1'b0, 1'b0, 1'b0, -1, "R3 R4 R5 R10");
    send_pkt(2, 1'b1, 1'b1, 1'b1, -1, "R3 R4 R10");
    send_pkt(10, 1'b0, 1'b0, 1'b0, -1, "R5 R10");
    send_os("R8 R10");

    // eight lanes
    lane_mode = 2'd2; mnl = 8;
    repeat (4) @(negedge clk);
    send_pkt(2, 1'b0, 1'b0, 1'b0, -1, "R3 R4 R7");
    send_pkt(2, 1'b1, 1'b0, 1'b1, -1, "R6");
    send_pkt(2, 1'b0, 1'b1, 1'b1, -1, "R6");
    send_pkt(6, 1'b1, 1'b0, 1'b0, -1, "R5 R6");
    send_pkt(14, 1'b0, 1'b0, 1'b0, 2, "R5 R8");
    send_os("R8");

    // encoding 3 also selects eight lanes
    lane_mode = 2'd3;
    repeat (4) @(negedge clk);
    send_pkt(2, 1'b1, 1'b0, 1'b0, -1, "R10 R7");

    repeat (30) @(negedge clk);
    check(exp_d.size() == 0, "R5 rows outstanding", 64'(exp_d.size()), 64'd0);
    check(idle_rows > 0, "R9 idle rows seen", 64'(idle_rows), 64'd1);
    finish_run();
  end

endmodule